// File: doc/BRIEF.md
# Quarter-Rate Digital Upconverter with Carrier Reference

This block sits between an interpolation filter and a high-rate DAC. Each accepted signed sample is rotated by a cosine at one quarter of the sample rate. The baseband content then leaves the block as a double-sideband suppressed-carrier signal centred at Fs/4, away from the low-frequency noise of the converter. In the default mode the rotation needs no multiplier: the four phases pass the sample, force zero, negate it and force zero.

A second mode uses the carrier shifted by 45 degrees. Its magnitude of 0.707 is built from shifts and adds as 181/256, with rounding. Next to the data, the block drives two complementary carrier reference lines for an external switching mixer that brings the signal back to baseband. Both lines come from the same phase state as the data path, so they stay aligned with the sample presented on the output.

Top module: `qrot_upconv`

## Requirements
- R1: While reset is asserted, and after it until a sample has passed through: `out_valid`=0, `out_data`=0, `carr_p`=1, `carr_n`=0. `in_ready` is 0 in reset and 1 from the first clock edge after release.
- R2: A sample accepted on a rising edge (`in_valid`=1 and `in_ready`=1) appears on `out_data` with `out_valid`=1 after the next rising edge. This is two register stages. `out_valid` is high only for such samples.
- R3: A 2-bit phase starts at 0 after reset and advances by one, modulo 4, for each accepted sample only. Idle cycles leave it unchanged.
- R4: With `in_mode`=0, phases 0, 1, 2 and 3 give x, 0, -x and 0.
- R5: Negating the most negative code (-2^(DW-1)) gives the most positive code, 2^(DW-1)-1.
- R6: With `in_mode`=1, phases 0 and 1 give s = floor((181*x + 128)/256), and phases 2 and 3 give -s.
- R7: `carr_p` and `carr_n` are always complementary. With each output sample, `carr_p` is 1 when that sample's phase was 0 or 1 and 0 when it was 2 or 3.
- R8: In cycles without an output sample, `out_data`, `carr_p` and `carr_n` keep their last values.
- R9: `in_mode` is taken with each sample on its own. Changing it between samples changes only later samples and does not disturb the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_mode | input | 1 | 0: 1,0,-1,0 carrier; 1: 45-degree carrier |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | DW | Signed rotated sample |
| carr_p | output | 1 | Carrier reference, high in phases 0 and 1 |
| carr_n | output | 1 | Carrier reference, high in phases 2 and 3 |

## Verification
The bench feeds the most negative code in the negating phase, where a design that wraps instead of saturating would return the same negative code. It sends gapped streams. A phase counter that runs freely would then put the zero and negate phases on the wrong samples, and the carrier lines would drift away from the data. The 45-degree mode is checked at the end codes and at small values of both signs, where rounding toward zero or truncating would differ from the floor-plus-half rule by one LSB. The bench also switches modes from sample to sample to expose any mode that is latched late or applied to the wrong stage.

// File: rtl/qrot_pkg.sv
package qrot_pkg;
  typedef logic [1:0] phase_t;
  typedef enum logic {MODE_COS = 1'b0, MODE_DIAG = 1'b1} mode_e;
endpackage

// File: rtl/qrot_phase_ctr.sv
module qrot_phase_ctr
  import qrot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  output phase_t phase
);
  phase_t ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else if (take) ph_q <= ph_q + 2'd1;
  end

  assign phase = ph_q;

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> phase == $past(phase) + 2'd1);
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(phase));
endmodule

// File: rtl/qrot_stage_in.sv
module qrot_stage_in
  import qrot_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  logic signed [DW-1:0] in_data,
  input  phase_t               phase,
  output logic                 ready,
  output logic                 take,
  output logic                 s1_valid,
  output logic signed [DW-1:0] s1_data,
  output phase_t               s1_phase,
  output mode_e                s1_mode
);
  logic ready_q;

  assign ready = ready_q;
  assign take  = in_valid && ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_phase <= '0;
      s1_mode  <= MODE_COS;
    end else begin
      ready_q  <= 1'b1;
      s1_valid <= take;
      if (take) begin
        s1_data  <= in_data;
        s1_phase <= phase;
        s1_mode  <= mode_e'(in_mode);
      end
    end
  end
endmodule

// File: rtl/qrot_mix_out.sv
module qrot_mix_out
  import qrot_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  input  logic signed [DW-1:0] s1_data,
  input  phase_t               s1_phase,
  input  mode_e                s1_mode,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int AW = DW + 9;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [AW-1:0] HALF = AW'(128);

  function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] x);
    if (x == MINV) return MAXV;
    return -x;
  endfunction

  function automatic logic signed [DW-1:0] scale_diag(input logic signed [DW-1:0] x);
    logic signed [AW-1:0] xe, acc;
    xe  = {{9{x[DW-1]}}, x};
    acc = (xe <<< 7) + (xe <<< 5) + (xe <<< 4) + (xe <<< 2) + xe + HALF;
    return acc[DW+7:8];
  endfunction

  logic signed [DW-1:0] mixed, scaled;
  logic                 hit_min_neg;

  always_comb begin
    scaled = scale_diag(s1_data);
    mixed  = '0;
    if (s1_mode == MODE_COS) begin
      case (s1_phase)
        2'd0:    mixed = s1_data;
        2'd2:    mixed = neg_sat(s1_data);
        default: mixed = '0;
      endcase
    end else begin
      mixed = s1_phase[1] ? neg_sat(scaled) : scaled;
    end
  end

  assign hit_min_neg = s1_valid && (s1_mode == MODE_COS) && (s1_phase == 2'd2)
                       && (s1_data == MINV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= mixed;
    end
  end

  assert_min_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_min_neg |=> out_data == MAXV);
  assert_odd_phase_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == MODE_COS && s1_phase[0]) |=> out_data == '0);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_data));
endmodule

// File: rtl/qrot_carrier.sv
module qrot_carrier
  import qrot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   s1_valid,
  input  phase_t s1_phase,
  output logic   carr_p,
  output logic   carr_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carr_p <= 1'b1;
      carr_n <= 1'b0;
    end else if (s1_valid) begin
      carr_p <= !s1_phase[1];
      carr_n <= s1_phase[1];
    end
  end

  assert_carrier_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    carr_p != carr_n);
  assert_carrier_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(carr_p) && $stable(carr_n)));
endmodule

// File: rtl/qrot_upconv.sv
module qrot_upconv
  import qrot_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          carr_p,
  output logic          carr_n
);
  phase_t               phase, s1_phase;
  mode_e                s1_mode;
  logic                 take, s1_valid;
  logic signed [DW-1:0] s1_data, mix_data;

  qrot_phase_ctr u_phase (
    .clk(clk), .rst_n(rst_n), .take(take), .phase(phase)
  );

  qrot_stage_in #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_data(in_data), .phase(phase), .ready(in_ready), .take(take),
    .s1_valid(s1_valid), .s1_data(s1_data), .s1_phase(s1_phase), .s1_mode(s1_mode)
  );

  qrot_mix_out #(.DW(DW)) u_mix (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_data(s1_data),
    .s1_phase(s1_phase), .s1_mode(s1_mode), .out_valid(out_valid), .out_data(mix_data)
  );

  qrot_carrier u_carr (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_phase(s1_phase),
    .carr_p(carr_p), .carr_n(carr_n)
  );

  assign out_data = mix_data;

  assert_two_stage_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(take, 2));
endmodule

// File: tb/sim_qrot_upconv.sv
module sim_qrot_upconv;
  localparam int DW = 16;
  localparam logic signed [DW-1:0] MAXV = 16'sh7FFF;
  localparam logic signed [DW-1:0] MINV = 16'sh8000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_mode = 1'b0, in_valid = 1'b0;
  logic          in_ready, out_valid, carr_p, carr_n;
  logic [DW-1:0] in_data = '0, out_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int    ph = 0;
  bit    p0_v = 0, p1_v = 0, p0_c = 0, p1_c = 0, last_c = 1;
  logic signed [DW-1:0] p0_d = '0, p1_d = '0, last_d = '0;
  string p0_t = "", p1_t = "";

  always #10 clk = ~clk;

  qrot_upconv #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_mode(in_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .carr_p(carr_p), .carr_n(carr_n)
  );

  function automatic logic signed [DW-1:0] model(input int x, input int p, input bit m);
    int s;
    if (!m) begin
      if (p == 1 || p == 3) return '0;
      if (p == 0) return DW'(x);
      return (x == -32768) ? MAXV : DW'(-x);
    end
    s = (x * 181 + 128) >>> 8;
    return (p < 2) ? DW'(s) : DW'(-s);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic step(input bit v, input int x, input bit m, input string tag);
    @(negedge clk);
    if (p1_v) begin
      chk(out_valid && out_data == p1_d && carr_p == p1_c && carr_n == !p1_c, p1_t,
          $sformatf("got v=%0b d=%0d p=%0b n=%0b, exp v=1 d=%0d p=%0b n=%0b",
                    out_valid, $signed(out_data), carr_p, carr_n, p1_d, p1_c, !p1_c));
      last_d = p1_d; last_c = p1_c;
    end else begin
      chk(!out_valid && out_data == last_d && carr_p == last_c && carr_n == !last_c, "R8",
          $sformatf("idle got v=%0b d=%0d p=%0b n=%0b, exp v=0 d=%0d p=%0b n=%0b",
                    out_valid, $signed(out_data), carr_p, carr_n, last_d, last_c, !last_c));
    end
    in_valid = v; in_data = DW'(x); in_mode = m;
    p1_v = p0_v; p1_d = p0_d; p1_c = p0_c; p1_t = p0_t;
    p0_v = v;
    if (v) begin
      p0_d = model(x, ph, m); p0_c = (ph < 2); p0_t = tag;
      ph = (ph + 1) % 4;
    end
  endtask

  task automatic flush();
    step(0, 0, 0, "R8");
    step(0, 0, 0, "R8");
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!in_ready && !out_valid && out_data == '0 && carr_p && !carr_n, "R1",
        $sformatf("reset got rdy=%0b v=%0b d=%0d p=%0b n=%0b, exp 0 0 0 1 0",
                  in_ready, out_valid, out_data, carr_p, carr_n));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && out_data == '0 && carr_p && !carr_n, "R1",
        $sformatf("after release got rdy=%0b v=%0b d=%0d, exp 1 0 0", in_ready, out_valid, out_data));
  endtask

  task automatic t_cos_walk();
    step(1, 1234, 0, "R4"); step(1, 555, 0, "R4");
    step(1, -2000, 0, "R4"); step(1, 77, 0, "R2");
    step(1, 32767, 0, "R4"); step(1, -1, 0, "R4");
    step(1, -32767, 0, "R4"); step(1, 9, 0, "R2");
    flush();
  endtask

  task automatic t_gaps();
    step(1, 300, 0, "R3"); step(0, 0, 0, "R3");
    step(1, 400, 0, "R3"); step(0, 0, 0, "R3"); step(0, 0, 0, "R3");
    step(1, 500, 0, "R3"); step(1, 600, 0, "R3"); step(0, 0, 0, "R3");
    step(1, 700, 0, "R3");
    flush();
  endtask

  task automatic t_saturate();
    while (ph != 2) step(1, 11, 0, "R4");
    step(1, -32768, 0, "R5");
    while (ph != 2) step(1, 12, 0, "R4");
    step(1, 32767, 0, "R5");
    while (ph != 0) step(1, 13, 0, "R4");
    step(1, -32768, 0, "R5");
    flush();
  endtask

  task automatic t_diag();
    step(1, 1000, 1, "R6"); step(1, -1000, 1, "R6");
    step(1, 32767, 1, "R6"); step(1, -32768, 1, "R6");
    step(1, 1, 1, "R6"); step(1, -1, 1, "R6");
    step(1, -32768, 1, "R6"); step(1, 32767, 1, "R6");
    step(1, 3, 1, "R6"); step(1, -3, 1, "R6");
    flush();
  endtask

  task automatic t_mode_switch();
    for (int i = 0; i < 12; i++) step(1, 2500 - 417 * i, i % 2, "R9");
    step(0, 0, 1, "R9");
    step(1, -4000, 0, "R9"); step(1, -4000, 1, "R9");
    flush();
  endtask

  task automatic t_carrier();
    for (int i = 0; i < 4; i++) begin
      step(1, 100 + i, 0, "R7");
      for (int j = 0; j < 3; j++) step(0, 0, 0, "R7");
    end
    flush();
  endtask

  initial begin
    t_reset();
    t_cos_walk();
    t_gaps();
    t_saturate();
    t_diag();
    t_mode_switch();
    t_carrier();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule